// File: doc/BRIEF.md
# Interleaved ADC sample reorderer

This block sits behind the capture path of a converter built from four internal sub-converters, named A, B, C and D. Every clock it may receive one capture word holding eight samples, two from each sub-converter. Of each pair, the delayed sample was taken earlier in time than its non-delayed partner. The block places these eight samples into eight output lanes in true time order for each logical input channel. Lane 0 of every channel holds the earliest sample.

The converter runs in one of three modes. In four-input mode each sub-converter is a channel of its own. In two-input mode A is paired with C and B is paired with D. In single-input mode all four sub-converters sample one input. The block registers its outputs and raises a per-channel mask that shows which lane groups carry data. It accepts a new mode only while the input is idle, and it discards the first word that arrives after a mode change, so that no output word mixes two orderings.

Top module: `adc_sort_top`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `out_valid` is 0 and `out_chmask` is 4'b0000. Reset selects four-input mode.
- R2: `out_valid` is 1 on the clock after an accepted input word and 0 otherwise. It is never high when `in_valid` was low on the previous clock.
- R3: `in_data` carries eight SAMPLE_W-bit fields. Field i sits at bits [i*SAMPLE_W +: SAMPLE_W], in the order 0=Ad, 1=A, 2=Bd, 3=B, 4=Cd, 5=C, 6=Dd, 7=D. In four-input mode (`in_mode` 2'b00), lane pair 2k,2k+1 carries sub-converter k (A,B,C,D) as delayed sample then non-delayed sample, so the lanes equal the fields unchanged.
- R4: In two-input mode (`in_mode` 2'b01), lanes 0..3 carry Ad, Cd, A, C and lanes 4..7 carry Bd, Dd, B, D.
- R5: In single-input mode (`in_mode` 2'b10), lanes 0..7 carry Ad, Bd, Cd, Dd, A, B, C, D.
- R6: `out_chmask` bit c marks channel c in use. Its value is 4'b1111 in four-input mode, 4'b0011 in two-input mode, 4'b0001 in single-input mode, and 4'b0000 whenever `out_valid` is 0.
- R7: In the reserved mode (`in_mode` 2'b11), every input word gives `out_valid` 0 and `out_chmask` 0.
- R8: `in_mode` takes effect only on a clock where `in_valid` is 0. A change presented while `in_valid` is 1 has no effect on the lane order.
- R9: After the active mode changes, the first word with `in_valid` 1 is discarded and produces no output. Words after it are reordered in the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture word present |
| in_mode | input | 2 | Requested interleave mode |
| in_data | input | 8*SAMPLE_W | Eight samples in the field order Ad, A, Bd, B, Cd, C, Dd, D |
| out_valid | output | 1 | Reordered word present |
| out_chmask | output | 4 | Channels in use |
| out_lanes | output | 8*SAMPLE_W | Time-ordered lanes, grouped by channel |

## Verification
The bench drives a new mode while words are still streaming. A design that sampled the mode at that point would switch orderings in the middle of the stream. The bench also checks the first word after every idle-time mode change, including a change into and out of the reserved code. A design without the discard would emit one word in the new mode's lane order too early, and a design that let the reserved code through would produce valid words with a bogus mask. Each mode is fed distinct sample values, so that a swapped delayed and non-delayed pair or an A/C versus B/D mix-up shows up as a lane mismatch. A reset in the middle of the stream confirms that the design falls back to four-input order without needing an idle clock.

// File: rtl/adc_sort_pkg.sv
package adc_sort_pkg;

  localparam int unsigned NUM_SUB   = 4;
  localparam int unsigned PER_SUB   = 2;
  localparam int unsigned NUM_LANES = NUM_SUB * PER_SUB;
  localparam int unsigned NUM_CHAN  = 4;

  typedef enum logic [1:0] {
    MODE_QUAD = 2'b00,
    MODE_DUAL = 2'b01,
    MODE_MONO = 2'b10,
    MODE_RSVD = 2'b11
  } sort_mode_e;

  // Input field index feeding a given output lane.
  // Field = 2*sub + half, where half 0 is the earlier (delayed) sample.
  function automatic int unsigned src_field(sort_mode_e m, int unsigned lane);
    int unsigned sub;
    int unsigned half;
    int unsigned pos;
    int unsigned grp;
    case (m)
      MODE_DUAL: begin
        grp  = lane / 4;
        pos  = lane % 4;
        sub  = grp + 2 * (pos % 2);
        half = pos / 2;
      end
      MODE_MONO: begin
        sub  = lane % NUM_SUB;
        half = lane / NUM_SUB;
      end
      default: begin
        sub  = lane / PER_SUB;
        half = lane % PER_SUB;
      end
    endcase
    return PER_SUB * sub + half;
  endfunction

  function automatic logic [NUM_CHAN-1:0] chan_mask(sort_mode_e m);
    case (m)
      MODE_QUAD: return 4'b1111;
      MODE_DUAL: return 4'b0011;
      MODE_MONO: return 4'b0001;
      default:   return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/adc_sort_modectl.sv
module adc_sort_modectl
  import adc_sort_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [1:0] in_mode,
  output sort_mode_e mode_q,
  output logic       accept
);

  logic drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_QUAD;
      drop_q <= 1'b0;
    end else if (!in_valid && (sort_mode_e'(in_mode) != mode_q)) begin
      mode_q <= sort_mode_e'(in_mode);
      drop_q <= 1'b1;
    end else if (in_valid) begin
      drop_q <= 1'b0;
    end
  end

  assign accept = in_valid && !drop_q && (mode_q != MODE_RSVD);

endmodule

// File: rtl/adc_sort_xbar.sv
module adc_sort_xbar
  import adc_sort_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  localparam int unsigned WORD_W  = NUM_LANES * SAMPLE_W
) (
  input  sort_mode_e        mode,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    localparam int unsigned F_QUAD = src_field(MODE_QUAD, l);
    localparam int unsigned F_DUAL = src_field(MODE_DUAL, l);
    localparam int unsigned F_MONO = src_field(MODE_MONO, l);

    always_comb begin
      case (mode)
        MODE_DUAL: dout[l*SAMPLE_W +: SAMPLE_W] = din[F_DUAL*SAMPLE_W +: SAMPLE_W];
        MODE_MONO: dout[l*SAMPLE_W +: SAMPLE_W] = din[F_MONO*SAMPLE_W +: SAMPLE_W];
        default:   dout[l*SAMPLE_W +: SAMPLE_W] = din[F_QUAD*SAMPLE_W +: SAMPLE_W];
      endcase
    end
  end

endmodule

// File: rtl/adc_sort_top.sv
module adc_sort_top
  import adc_sort_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12,
  localparam int unsigned WORD_W  = NUM_LANES * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [1:0]          in_mode,
  input  logic [WORD_W-1:0]   in_data,
  output logic                out_valid,
  output logic [NUM_CHAN-1:0] out_chmask,
  output logic [WORD_W-1:0]   out_lanes
);

  sort_mode_e        mode_q;
  logic              accept;
  logic [WORD_W-1:0] lanes_c;

  adc_sort_modectl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_mode  (in_mode),
    .mode_q   (mode_q),
    .accept   (accept)
  );

  adc_sort_xbar #(.SAMPLE_W(SAMPLE_W)) u_xbar (
    .mode (mode_q),
    .din  (in_data),
    .dout (lanes_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_chmask <= '0;
      out_lanes  <= '0;
    end else begin
      out_valid  <= accept;
      out_chmask <= accept ? chan_mask(mode_q) : '0;
      if (accept) out_lanes <= lanes_c;
    end
  end

endmodule

// File: rtl/adc_sort_chk.sv
module adc_sort_chk #(
  parameter int unsigned SAMPLE_W = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [1:0]            in_mode,
  input logic [8*SAMPLE_W-1:0] in_data,
  input logic                  out_valid,
  input logic [3:0]            out_chmask,
  input logic [8*SAMPLE_W-1:0] out_lanes
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_chmask == 4'b0000));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R6
  mask_code_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_chmask == 4'b1111 || out_chmask == 4'b0011 || out_chmask == 4'b0001));

  // R6
  mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_chmask == 4'b0000);

  // R3
  quad_order_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_chmask == 4'b1111) |-> out_lanes == $past(in_data));

  // R4
  dual_order_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_chmask == 4'b0011) |->
      (out_lanes[1*SAMPLE_W +: SAMPLE_W] == $past(in_data[4*SAMPLE_W +: SAMPLE_W]) &&
       out_lanes[4*SAMPLE_W +: SAMPLE_W] == $past(in_data[2*SAMPLE_W +: SAMPLE_W])));

  // R5
  mono_order_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_chmask == 4'b0001) |->
      (out_lanes[1*SAMPLE_W +: SAMPLE_W] == $past(in_data[2*SAMPLE_W +: SAMPLE_W]) &&
       out_lanes[4*SAMPLE_W +: SAMPLE_W] == $past(in_data[1*SAMPLE_W +: SAMPLE_W])));

endmodule

bind adc_sort_top adc_sort_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_mode    (in_mode),
  .in_data    (in_data),
  .out_valid  (out_valid),
  .out_chmask (out_chmask),
  .out_lanes  (out_lanes)
);

// File: tb/sim_adc_sort_top.sv
`timescale 1ns/1ps
module sim_adc_sort_top;

  localparam int W = 12;

  logic           clk = 1'b0;
  logic           rst;
  logic           in_valid;
  logic [1:0]     in_mode;
  logic [8*W-1:0] in_data;
  logic           out_valid;
  logic [3:0]     out_chmask;
  logic [8*W-1:0] out_lanes;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  // reference state
  int ref_mode = 0;
  bit ref_drop = 0;

  int ord_quad[8] = '{0, 1, 2, 3, 4, 5, 6, 7};
  int ord_dual[8] = '{0, 4, 1, 5, 2, 6, 3, 7};
  int ord_mono[8] = '{0, 2, 4, 6, 1, 3, 5, 7};

  always #2 clk = ~clk;

  adc_sort_top #(.SAMPLE_W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_data(in_data), .out_valid(out_valid), .out_chmask(out_chmask),
    .out_lanes(out_lanes)
  );

  task automatic check(string tag, string what, logic [8*W-1:0] act, logic [8*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at a negedge, predict, then compare at the next negedge.
  task automatic step(bit r, bit v, int m, logic [8*W-1:0] d);
    bit             e_v;
    logic [3:0]     e_mask;
    logic [8*W-1:0] e_lanes;
    string          tag;
    int             ord[8];
    rst = r; in_valid = v; in_mode = m[1:0]; in_data = d;
    e_v = 0; e_mask = 4'b0000; e_lanes = '0; tag = "R2";
    if (r) begin
      ref_mode = 0; ref_drop = 0; tag = "R1";
    end else if (!v) begin
      if (m != ref_mode) begin ref_mode = m; ref_drop = 1; end
    end else if (ref_drop) begin
      ref_drop = 0; tag = "R9";
    end else if (ref_mode == 3) begin
      tag = "R7";
    end else begin
      e_v = 1;
      case (ref_mode)
        0: begin ord = ord_quad; e_mask = 4'b1111; tag = "R3"; end
        1: begin ord = ord_dual; e_mask = 4'b0011; tag = "R4"; end
        default: begin ord = ord_mono; e_mask = 4'b0001; tag = "R5"; end
      endcase
      if (m != ref_mode) tag = {tag, "/R8"};
      for (int k = 0; k < 8; k++) e_lanes[k*W +: W] = d[ord[k]*W +: W];
    end
    @(negedge clk);
    check(tag, "out_valid", {95'd0, out_valid}, {95'd0, e_v});
    check((tag == "R1") ? "R1" : "R6", "out_chmask", {92'd0, out_chmask}, {92'd0, e_mask});
    if (e_v) check(tag, "out_lanes", out_lanes, e_lanes);
  endtask

  function automatic logic [8*W-1:0] pattern(int seed);
    logic [8*W-1:0] w;
    for (int k = 0; k < 8; k++) w[k*W +: W] = W'(seed * 16 + k + 1);
    return w;
  endfunction

  initial begin
    rst = 1; in_valid = 0; in_mode = 0; in_data = '0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1, 1, 2, pattern(i));          // R1
    for (int i = 0; i < 4; i++) step(0, 1, 0, pattern(10 + i));     // R3
    step(0, 0, 0, '0);                                               // R2 idle
    step(0, 0, 1, '0);                                               // switch to dual
    step(0, 1, 1, pattern(20));                                      // R9 dropped
    for (int i = 0; i < 4; i++) step(0, 1, 1, pattern(21 + i));     // R4
    for (int i = 0; i < 3; i++) step(0, 1, 2, pattern(30 + i));     // R8 ignored
    step(0, 0, 2, '0);                                               // switch to mono
    step(0, 1, 2, pattern(40));                                      // R9
    for (int i = 0; i < 6; i++) step(0, i % 2, 2, pattern(41 + i)); // R5, R2 bubbles
    step(0, 0, 3, '0);                                               // reserved
    for (int i = 0; i < 4; i++) step(0, 1, 3, pattern(50 + i));     // R7
    step(0, 0, 0, '0);
    step(0, 1, 0, pattern(60));                                      // R9
    step(0, 1, 0, pattern(61));                                      // R3
    for (int i = 0; i < 400; i++)
      step(0, ($urandom % 4) != 0, int'($urandom % 4), {$urandom, $urandom, $urandom});
    step(0, 0, 2, '0);
    step(1, 1, 2, pattern(70));                                      // R1 mid-run
    for (int i = 0; i < 3; i++) step(0, 1, 2, pattern(71 + i));     // quad after reset, R8
    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<5000 cycles", cycles);
      done = 1;
    end
  end

  initial begin
    wait (done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule